// File: doc/BRIEF.md
# Cascadable Offset Binary Up-Counter

This block is a synchronous binary up-counter, four bits wide by default, clocked on the rising edge. It has three synchronous controls. A clear sets the count to zero. A parallel load copies a data word into the count. A count enable lets the count advance by one on each edge. All of these act only at the clock edge, and the block has no asynchronous reset.

A carry output is high when the count holds its all-ones value and the enable is asserted. Feeding this carry into the enable of the next stage chains several counters into one wider counter.

Two mode pins change where the sequence wraps:
- With the start-offset mode on, the wrap point reloads a programmable start value instead of zero.
- With the end-offset mode on, a comparator makes the programmable end value the wrap point, so the count wraps there before it reaches all-ones.

With both modes on, the counter cycles over the range from the start value to the end value.

These are control pins, not a data stream. The block therefore has no valid/ready handshake and no back-pressure. The count is visible on the output at all times.

Top module: `offset_up_counter`

## Requirements
- R1: While `clr` is high at a rising edge, the count becomes 0 after that edge, whatever the other inputs are.
- R2: While `clr` is low and `ld` is high at an edge, the count becomes `ld_val` after that edge, whether `en` is high or low.
- R3: While `clr`, `ld` and `en` are all low at an edge, the count keeps its value.
- R4: While counting (`en` high, `clr` and `ld` low) and the count is not at a wrap point, the count increases by exactly one per edge.
- R5: With both modes off, an enabled edge at count all-ones (15 by default) gives 0.
- R6: With `start_mode` high, an enabled edge at count all-ones gives `start_val` instead of 0.
- R7: With `end_mode` high and `start_mode` low, an enabled edge at a count equal to `end_val` gives 0.
- R8: With both modes high, an enabled edge at a count equal to `end_val` gives `start_val`, so the counter cycles from `start_val` to `end_val`.
- R9: `carry_out` is 1 exactly when `en` is 1 and every count bit is 1. This output is combinational and shows no register delay.
- R10: Two stages, where the upper stage's `en` is driven by the lower stage's `carry_out` and both share one clear, count as one binary counter of twice the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear; highest priority |
| ld | input | 1 | Synchronous parallel load; priority over counting |
| en | input | 1 | Count enable; also qualifies the carry output |
| ld_val | input | W | Value taken by a load |
| start_val | input | W | Value reloaded at the wrap point in start-offset mode |
| end_val | input | W | Compare value that ends the sequence in end-offset mode |
| start_mode | input | 1 | Enables the start-offset reload |
| end_mode | input | 1 | Enables the end-value compare |
| count | output | W | Current count |
| carry_out | output | 1 | High when en is high and count is all-ones |

## Verification

Clear, load, hold and step each show on `count` one edge after the edge that samples them, because `count` is the only register. `carry_out` follows `en` and `count` within the same cycle.

The bench changes inputs 2 ns after a rising edge, so no input moves at an active edge. After each edge it waits another 2 ns before it compares `count` with the expected value. For the carry, it compares the output 1 ns after it changes `en`, with no edge in between.

Long runs are stepped one edge at a time. The expected value is advanced in step with each edge. In the cascade test, the combined value of the two stages is compared with the number of edges that have elapsed.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_toggle_inc.sv
// Increment by a toggle chain: bit i flips when all lower bits are 1.
module cnt_toggle_inc #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt,
  output logic         all_ones
);
  logic [W:0] flip;

  assign flip[0] = 1'b1;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign nxt[i]    = cur[i] ^ flip[i];
      assign flip[i+1] = flip[i] & cur[i];
    end
  endgenerate

  assign all_ones = flip[W];
endmodule

// File: rtl/cnt_wrap_sel.sv
// Picks the value that follows an enabled counting edge.
module cnt_wrap_sel #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] inc,
  input  logic         all_ones,
  input  logic [W-1:0] start_val,
  input  logic [W-1:0] end_val,
  input  logic         start_mode,
  input  logic         end_mode,
  output logic [W-1:0] step_val
);
  logic end_hit;
  logic wrap;
  logic [W-1:0] restart;

  assign end_hit = end_mode && (cur == end_val);
  assign wrap    = end_hit || all_ones;
  assign restart = start_mode ? start_val : '0;

  always_comb begin
    if (wrap) step_val = restart;
    else      step_val = inc;
  end
endmodule

// File: rtl/offset_up_counter.sv
module offset_up_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic         en,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] start_val,
  input  logic [W-1:0] end_val,
  input  logic         start_mode,
  input  logic         end_mode,
  output logic [W-1:0] count,
  output logic         carry_out
);
  import cnt_pkg::*;

  logic [W-1:0] cnt_q;
  logic [W-1:0] inc_val;
  logic [W-1:0] step_val;
  logic         top_hit;
  cnt_op_e      op;

  cnt_toggle_inc #(.W(W)) u_inc (
    .cur      (cnt_q),
    .nxt      (inc_val),
    .all_ones (top_hit)
  );

  cnt_wrap_sel #(.W(W)) u_wrap (
    .cur        (cnt_q),
    .inc        (inc_val),
    .all_ones   (top_hit),
    .start_val  (start_val),
    .end_val    (end_val),
    .start_mode (start_mode),
    .end_mode   (end_mode),
    .step_val   (step_val)
  );

  always_comb begin
    if (clr)     op = OP_CLEAR;
    else if (ld) op = OP_LOAD;
    else if (en) op = OP_STEP;
    else         op = OP_HOLD;
  end

  always_ff @(posedge clk) begin
    unique case (op)
      OP_CLEAR: cnt_q <= '0;
      OP_LOAD:  cnt_q <= ld_val;
      OP_STEP:  cnt_q <= step_val;
      default:  cnt_q <= cnt_q;
    endcase
  end

  assign count     = cnt_q;
  assign carry_out = en & top_hit;
endmodule

// File: rtl/offset_up_counter_chk.sv
module offset_up_counter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr,
  input logic         ld,
  input logic         en,
  input logic [W-1:0] ld_val,
  input logic [W-1:0] start_val,
  input logic [W-1:0] end_val,
  input logic         start_mode,
  input logic         end_mode,
  input logic [W-1:0] count,
  input logic         carry_out
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (clr) armed <= 1'b1;

  logic         at_wrap;
  logic [W-1:0] wrap_to;
  assign at_wrap = (end_mode && count == end_val) || (count == {W{1'b1}});
  assign wrap_to = start_mode ? start_val : {W{1'b0}};

  assert_clear_R1: assert property (@(posedge clk) disable iff (!armed)
    clr |=> count == '0);
  assert_load_R2: assert property (@(posedge clk) disable iff (!armed)
    (!clr && ld) |=> count == $past(ld_val));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && !en) |=> $stable(count));
  assert_step_R4: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && en && !at_wrap) |=> count == $past(count) + 1'b1);
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !ld && en && at_wrap) |=> count == $past(wrap_to));
  assert_carry_R9: assert property (@(posedge clk) disable iff (!armed)
    carry_out == (en && count == {W{1'b1}}));
endmodule

bind offset_up_counter offset_up_counter_chk #(.W(W)) u_chk (
  .clk(clk), .clr(clr), .ld(ld), .en(en), .ld_val(ld_val),
  .start_val(start_val), .end_val(end_val), .start_mode(start_mode),
  .end_mode(end_mode), .count(count), .carry_out(carry_out)
);

// File: tb/sim_offset_up_counter.sv
`timescale 1ns/1ps
module sim_offset_up_counter;
  localparam int W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         clr, ld, en, start_mode, end_mode;
  logic [W-1:0] ld_val, start_val, end_val, count;
  logic         carry_out;
  logic         ld1;
  logic [W-1:0] count1;
  logic         carry1;

  int checks = 0;
  int errors = 0;

  offset_up_counter #(.W(W)) u0 (
    .clk(clk), .clr(clr), .ld(ld), .en(en), .ld_val(ld_val),
    .start_val(start_val), .end_val(end_val), .start_mode(start_mode),
    .end_mode(end_mode), .count(count), .carry_out(carry_out)
  );

  offset_up_counter #(.W(W)) u1 (
    .clk(clk), .clr(clr), .ld(ld1), .en(carry_out), .ld_val('0),
    .start_val('0), .end_val('0), .start_mode(1'b0),
    .end_mode(1'b0), .count(count1), .carry_out(carry1)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    clr = 0; ld = 0; en = 0; ld1 = 0;
    start_mode = 0; end_mode = 0;
  endtask

  task automatic do_load(input logic [W-1:0] v);
    ld = 1; ld_val = v;
    edge_step();
    ld = 0;
  endtask

  task automatic t_reset();
    idle(); clr = 1; ld = 1; en = 1; ld_val = 4'd9;
    edge_step();
    chk("R1", count, 0);
    chk("R1", count1, 0);
    idle();
  endtask

  task automatic t_load();
    idle(); en = 0;
    do_load(4'd11);
    chk("R2", count, 11);
    en = 1;
    do_load(4'd3);
    chk("R2", count, 3);
    idle();
  endtask

  task automatic t_hold();
    idle();
    do_load(4'd7);
    for (int k = 0; k < 3; k++) edge_step();
    chk("R3", count, 7);
  endtask

  task automatic t_step();
    idle();
    do_load(4'd0);
    en = 1;
    for (int k = 1; k <= 15; k++) begin
      edge_step();
      if (k == 1 || k == 8 || k == 15) chk("R4", count, k);
    end
    edge_step();
    chk("R5", count, 0);
    idle();
  endtask

  task automatic t_carry();
    idle();
    do_load(4'd15);
    #1 chk("R9", carry_out, 0);
    en = 1;
    #1 chk("R9", carry_out, 1);
    edge_step();
    chk("R9", carry_out, 0);
    idle();
  endtask

  task automatic t_start();
    idle(); start_mode = 1; start_val = 4'd6;
    do_load(4'd14);
    en = 1;
    edge_step(); chk("R4", count, 15);
    edge_step(); chk("R6", count, 6);
    edge_step(); chk("R6", count, 7);
    idle();
  endtask

  task automatic t_end();
    idle(); end_mode = 1; end_val = 4'd13;
    do_load(4'd0);
    en = 1;
    for (int k = 1; k <= 13; k++) edge_step();
    chk("R7", count, 13);
    edge_step(); chk("R7", count, 0);
    idle();
  endtask

  task automatic t_range();
    idle(); start_mode = 1; end_mode = 1;
    start_val = 4'd6; end_val = 4'd12;
    do_load(4'd10);
    en = 1;
    edge_step(); chk("R8", count, 11);
    edge_step(); chk("R8", count, 12);
    edge_step(); chk("R8", count, 6);
    edge_step(); chk("R8", count, 7);
    idle();
  endtask

  task automatic t_cascade();
    idle(); clr = 1;
    edge_step();
    clr = 0; en = 1;
    for (int k = 1; k <= 40; k++) begin
      edge_step();
      if (k == 15 || k == 16 || k == 36 || k == 40)
        chk("R10", {count1, count}, k);
    end
    idle();
  endtask

  initial begin
    idle();
    ld_val = '0; start_val = '0; end_val = '0;
    #2;
    t_reset();
    t_load();
    t_hold();
    t_step();
    t_carry();
    t_start();
    t_end();
    t_range();
    t_cascade();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule